// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Wait-State Controller

This block sits between a processor bus that can present the next address early and a memory built from two interleaved DRAM banks. Each time the bus opens a cycle, the block picks the bank from one address bit and works out how many wait states the cycle needs. It then drives that bank's row and column strobes and raises a one-clock ready pulse that ends the cycle.

Each bank has its own precharge timer, which starts when the bank's row strobe is released. An access to a bank whose timer is still running pays the longer same-bank wait. An access to a bank that has finished precharging pays only the short interleaved wait. A cycle whose address came late, and any cycle that follows an idle bus clock, pays one extra wait. A write can pay one more. All wait counts and the precharge length are compile-time parameters, and the parameters must satisfy W_SAME >= T_PRE.

Top module: `dram_ilv_ctrl`

## Requirements
- R1: During and right after reset, `ras_n` and `cas_n` are both 2'b11 and `ready` is 0. Both banks count as precharged, and the first cycle counts as following an idle bus.
- R2: A read to a bank whose precharge timer is zero, with `addr_piped`=1 and no idle clock since the last cycle, gets W_PIPE wait states. Ready is high in clock 2+W_PIPE, where clock 1 is the clock in which `cyc_start` is high.
- R3: If the target bank is precharged and either `addr_piped`=0 or `bus_idle` was sampled high in an idle clock since the previous cycle (or since reset), the cycle gets W_PIPE+1 wait states.
- R4: If the target bank's precharge timer is nonzero in the start clock, the cycle gets W_SAME wait states. This applies whatever the pipelining.
- R5: When WR_PEN=1, a write (`wr`=1) gets one wait state more than the same read would get under R2 to R4.
- R6: Ready is high for exactly one clock per cycle. A `cyc_start` pulse that arrives while a cycle is in progress is ignored and does not change that cycle's length.
- R7: A bank's precharge timer loads T_PRE at the clock edge that ends a cycle on that bank and then counts down by one every clock. That bank's row strobe is never low while its timer is nonzero.
- R8: At most one bank's strobes are active at a time. A bank's CAS is low only while its RAS is low, and CAS is low in the ready clock.
- R9: `bank_sel`=0 selects bank 0, which uses bit 0 of `ras_n` and `cas_n`. `bank_sel`=1 selects bank 1, which uses bit 1. The other bank's strobes stay high for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse that opens a bus cycle; sampled only between cycles |
| addr_piped | input | 1 | Address of this cycle was issued early |
| wr | input | 1 | 1 = write, 0 = read |
| bank_sel | input | 1 | Lowest word-address bit; picks the bank |
| bus_idle | input | 1 | Bus has no cycle pending in this clock |
| ras_n | output | 2 | Active-low row strobes, one per bank |
| cas_n | output | 2 | Active-low column strobes, one per bank |
| ready | output | 1 | One-clock pulse that ends the bus cycle |

## Verification
A wrong precharge timer shows up at the ports within one bus cycle. A bank read as busy when it is free stretches ready to the same-bank count, and a bank read as free when it is busy cuts ready short. A stale timer also shows as a row strobe that stays high for some clocks of an access to that bank. A stuck idle flag adds or removes exactly one wait state on the next cycle. A wrong counter or bank register appears in the same cycle, as a ready pulse in the wrong clock or strobes on the wrong bit. For this reason the bench checks the clock in which ready appears and checks the strobes in every clock of every cycle.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACT  = 1'b1
    } dil_state_e;
endpackage

// File: rtl/dram_bank_timer.sv
module dram_bank_timer #(
    parameter int T_PRE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    output logic busy_o
);
    localparam int TW = $clog2(T_PRE + 2);

    logic [TW-1:0] cnt_d, cnt_q;

    assign busy_o = (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (release_i)
            cnt_d = TW'(T_PRE);
        else if (busy_o)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // A bank is only released after its row strobe was active, which needs a spent timer
    assert_release_after_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> !busy_o);
endmodule

// File: rtl/dram_wait_calc.sv
module dram_wait_calc #(
    parameter int W_PIPE = 0,
    parameter int W_SAME = 2,
    parameter bit WR_PEN = 1'b1,
    parameter int WW     = 3
) (
    input  logic          pend_i,
    input  logic          unpiped_i,
    input  logic          wr_i,
    output logic [WW-1:0] waits_o
);
    logic [WW-1:0] base;
    logic          wr_add;

    always_comb begin
        if (pend_i)
            base = WW'(W_SAME);
        else
            base = WW'(W_PIPE) + WW'(unpiped_i);
        wr_add  = WR_PEN & wr_i;
        waits_o = base + WW'(wr_add);
    end
endmodule

// File: rtl/dram_ilv_ctrl.sv
module dram_ilv_ctrl #(
    parameter int W_PIPE = 0,
    parameter int W_SAME = 2,
    parameter int T_PRE  = 2,
    parameter bit WR_PEN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       addr_piped,
    input  logic       wr,
    input  logic       bank_sel,
    input  logic       bus_idle,
    output logic [1:0] ras_n,
    output logic [1:0] cas_n,
    output logic       ready
);
    import dram_ilv_pkg::*;

    localparam int NB = 2;
    localparam int WW = $clog2(W_PIPE + W_SAME + 3);

    typedef struct packed {
        dil_state_e    st;
        logic [WW-1:0] cnt;
        logic          bank;
        logic          ras_seen;
        logic          after_idle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NB-1:0] busy, rel, ras_on, cas_on;
    logic [WW-1:0] waits;
    logic          ready_c;
    logic          unpiped;

    assign ready_c = (ctl_q.st == ST_ACT) && (ctl_q.cnt == '0);
    assign unpiped = !addr_piped || ctl_q.after_idle;

    dram_wait_calc #(
        .W_PIPE(W_PIPE), .W_SAME(W_SAME), .WR_PEN(WR_PEN), .WW(WW)
    ) u_calc (
        .pend_i   (busy[bank_sel]),
        .unpiped_i(unpiped),
        .wr_i     (wr),
        .waits_o  (waits)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        dram_bank_timer #(.T_PRE(T_PRE)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .release_i(rel[b]),
            .busy_o   (busy[b])
        );
        assign ras_on[b] = (ctl_q.st == ST_ACT) && (int'(ctl_q.bank) == b) && !busy[b];
        assign cas_on[b] = ras_on[b] && (ctl_q.ras_seen || ready_c);
        assign rel[b]    = ready_c && (int'(ctl_q.bank) == b);
        assign ras_n[b]  = !ras_on[b];
        assign cas_n[b]  = !cas_on[b];

        // Precharge may only begin once the row strobe has been active
        assert_timer_after_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[b]) |-> $past(!ras_n[b]));
    end

    assign ready = ready_c;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.st == ST_IDLE) begin
            if (cyc_start) begin
                ctl_d.st         = ST_ACT;
                ctl_d.cnt        = waits;
                ctl_d.bank       = bank_sel;
                ctl_d.ras_seen   = 1'b0;
                ctl_d.after_idle = 1'b0;
            end else if (bus_idle) begin
                ctl_d.after_idle = 1'b1;
            end
        end else begin
            if (ras_on[ctl_q.bank])
                ctl_d.ras_seen = 1'b1;
            if (ctl_q.cnt == '0)
                ctl_d.st = ST_IDLE;
            else
                ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st         <= ST_IDLE;
            ctl_q.cnt        <= '0;
            ctl_q.bank       <= 1'b0;
            ctl_q.ras_seen   <= 1'b0;
            ctl_q.after_idle <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ras_n) <= 1);

    assert_cas_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ($countones(~cas_n) == 1));
endmodule

// File: tb/sim_dram_ilv_ctrl.sv
module sim_dram_ilv_ctrl;
    localparam int WP  = 0;
    localparam int WS  = 2;
    localparam int TP  = 2;
    localparam bit WRP = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       addr_piped = 1'b0;
    logic       wr = 1'b0;
    logic       bank_sel = 1'b0;
    logic       bus_idle = 1'b0;
    logic [1:0] ras_n, cas_n;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int mt[2];
    bit m_idle;

    always #4 clk = ~clk;

    dram_ilv_ctrl #(.W_PIPE(WP), .W_SAME(WS), .T_PRE(TP), .WR_PEN(WRP)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .addr_piped(addr_piped),
        .wr(wr), .bank_sel(bank_sel), .bus_idle(bus_idle),
        .ras_n(ras_n), .cas_n(cas_n), .ready(ready)
    );

    function automatic int exp_waits(input bit b, input bit w, input bit p);
        int n;
        if (mt[b] != 0) n = WS;
        else            n = WP + ((!p || m_idle) ? 1 : 0);
        if (WRP && w) n = n + 1;
        return n;
    endfunction

    function automatic string tag_of(input bit b, input bit w, input bit p);
        if (WRP && w)      return "R5";
        if (mt[b] != 0)    return "R4";
        if (!p || m_idle)  return "R3";
        return "R2";
    endfunction

    // model of the per-bank timers across one clock edge
    task automatic step(input bit rel, input bit b);
        for (int i = 0; i < 2; i++) begin
            if (rel && i == int'(b)) mt[i] = TP;
            else if (mt[i] > 0)      mt[i] = mt[i] - 1;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // entered and left at a falling edge
    task automatic gap(input int n, input bit idle);
        for (int i = 0; i < n; i++) begin
            cyc_start = 1'b0;
            bus_idle  = idle;
            @(posedge clk);
            step(1'b0, 1'b0);
            if (idle) m_idle = 1'b1;
            @(negedge clk);
        end
        bus_idle = 1'b0;
    endtask

    task automatic do_cycle(input bit b, input bit w, input bit p, input bit poke);
        int    e, k;
        bit    done, sbad;
        int    sact, sexp;
        string t;
        e = exp_waits(b, w, p);
        t = tag_of(b, w, p);
        cyc_start = 1'b1; bank_sel = b; wr = w; addr_piped = p; bus_idle = 1'b0;
        @(posedge clk);
        step(1'b0, b);
        m_idle = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        k = 2; done = 0; sbad = 0; sact = 0; sexp = 0;
        while (!done && k < 40) begin
            // R7/R9: addressed RAS low exactly when its modeled timer is spent; other bank idle
            if (ras_n[b] != (mt[b] != 0) || ras_n[!b] != 1'b1 || cas_n[!b] != 1'b1) begin
                if (!sbad) begin sact = {ras_n, cas_n}; sexp = {b ? 1'b0 : 1'b1, b ? 1'b1 : 1'b0, 2'b00}; end
                sbad = 1;
            end
            if (ready) begin
                done = 1;
                // R8: CAS of the addressed bank low in the ready clock
                if (cas_n[b] != 1'b0) begin sbad = 1; sact = cas_n; sexp = b ? 1 : 2; end
            end
            if (poke && k == 2) begin
                cyc_start = 1'b1; bank_sel = !b;
            end
            @(posedge clk);
            step(done, b);
            @(negedge clk);
            cyc_start = 1'b0;
            if (!done) k++;
        end
        check(done && (k - 2) == e, t, k - 2, e);
        check(!sbad, "R7 R8 R9 strobes", sact, sexp);
        // R6: ready lasts one clock, and no extra cycle started from an ignored pulse
        check(ready == 1'b0 && ras_n == 2'b11, "R6", {ready, ras_n}, 3);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mt[0] = 0; mt[1] = 0; m_idle = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(ras_n == 2'b11 && cas_n == 2'b11 && ready == 1'b0, "R1", {ras_n, cas_n, ready}, 30);
        rst_n = 1'b1;
        @(negedge clk);
        check(ras_n == 2'b11 && cas_n == 2'b11 && ready == 1'b0, "R1", {ras_n, cas_n, ready}, 30);

        do_cycle(1'b0, 1'b0, 1'b1, 1'b0); // R3: first cycle after reset, expect 1
        do_cycle(1'b1, 1'b0, 1'b1, 1'b0); // R2: opposite bank, expect 0
        do_cycle(1'b1, 1'b0, 1'b1, 1'b0); // R4: same bank, expect 2
        do_cycle(1'b1, 1'b1, 1'b1, 1'b0); // R5: same bank write, expect 3
        do_cycle(1'b0, 1'b1, 1'b1, 1'b0); // R5: opposite bank write, expect 1
        gap(3, 1'b1);
        do_cycle(1'b0, 1'b0, 1'b1, 1'b0); // R3: after idle, precharge done, expect 1
        do_cycle(1'b1, 1'b0, 1'b0, 1'b0); // R3: unpipelined, expect 1
        do_cycle(1'b0, 1'b0, 1'b1, 1'b1); // R6: mid-cycle start ignored, expect 0
        gap(1, 1'b0);
        do_cycle(1'b0, 1'b0, 1'b1, 1'b0); // R4: timer still running after a busy gap
        do_cycle(1'b0, 1'b0, 1'b0, 1'b0); // R4: same bank wins over unpipelined

        for (int n = 0; n < 300; n++) begin
            int g;
            g = $urandom_range(0, 3);
            if (g != 0 && $urandom_range(0, 3) != 0) gap(g, $urandom_range(0, 1) == 1);
            do_cycle($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
                     $urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule